// File: doc/BRIEF.md
# Embedded CPU Debug and Halt Controller

This block sits next to a small pipelined RISC core and lets a host stop it, inspect it and restart it. The host reaches four registers through a simple register port: a mode register with an explicit halt request and two page-zero watch enables, a state register, a program counter override, and a hardware breakpoint address with its own disable bit. Host writes take effect on the clock edge. Reads are combinational from the current address.

From the core the block takes the live PC, a decode-valid flag, the data access address, its size and a valid flag, a data stall flag, and single-cycle fault and trap pulses. It turns these into sticky cause flags that the host clears by writing ones. The state register also shows two live status bits: the explicit halt request and the data stall. While the core is halted the host may load a new PC. That load also flushes the decode stage. The halt output stays high while the explicit halt request is set, or while any flag that stops the core is still pending.

Top module: `cpu_dbg_ctrl`

## Requirements
- R1: A host write to the PC offset 0x1C while `core_halt` is low is dropped. In the next cycle `core_pc_load` stays low and `core_pc_value` keeps its previous value.
- R2: A host write to 0x1C while `core_halt` is high is accepted. In the following cycle `core_pc_load` and `core_dec_flush` are high for exactly one cycle, and `core_pc_value` equals the written data with bits 1:0 forced to zero.
- R3: A read at 0x1C returns the live `core_pc` with bits 1:0 read as zero, whether or not the core is halted.
- R4: The breakpoint register is at 0x34. Bits 31:2 hold the address, bit 0 is the disable bit (reset value 1), and bits 1 and 31:2 read back as written. A hit needs all of the following: bit 0 is clear, `core_halt` is low, `core_dec_valid` is high, and `core_pc` equals the address with bits 1:0 equal to zero. A hit sets state bit 0 in the next cycle, and that bit halts the core.
- R5: State register bits at 0x04: 9 register trap, 8 memory trap, 7 bad alignment, 6 invalid fetch, 5 invalid data access, 4 page-zero instruction, 3 page-zero data, 2 invalid instruction, 1 halt instruction, 0 breakpoint. Each bit is sticky and is cleared by a host write of 1 to that bit. Writing 0 leaves the bit unchanged.
- R6: When an event and a write-one-to-clear hit the same state bit in the same cycle, the bit is set after that cycle.
- R7: State bit 10 mirrors mode bit 10. State bit 14 shows `core_dstall` in the same cycle. State bits 13:11 and 31:15 read as zero.
- R8: A data access with `core_dacc_valid` high sets bit 7 in two cases. Word accesses (`core_dsize`=2) set it when address bits 1:0 are not zero. Halfword accesses (`core_dsize`=1) set it when address bit 0 is one. Byte accesses (0) and the reserved size code 3 never set it.
- R9: Bit 4 is set when mode bit 2 is on, `core_dec_valid` is high and `core_pc` is below 256. Bit 3 is set when mode bit 3 is on, `core_dacc_valid` is high and `core_daddr` is below 256.
- R10: Input pulses set their state bits in the next cycle: `trap_reg` sets bit 9, `trap_mem` bit 8, `core_bad_fetch` bit 6, `core_bad_daccess` bit 5, `core_bad_instr` bit 2 and `core_halt_instr` bit 1.
- R11: `core_halt` is high exactly when mode bit 10 is set or any of state bits 0, 1, 2 or 6 is set. It is driven from registers, so it rises in the cycle after the causing write or event.
- R12: After reset the following hold. Mode reads 0. State reads 0 apart from bit 14. The breakpoint reads 0x1, all outputs are low and `core_pc_value` is 0. Mode keeps only bits 2, 3 and 10, and its other bits read as zero. Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Register byte offset for read and write |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| core_pc | input | 32 | Live program counter of the core |
| core_dec_valid | input | 1 | Decode stage holds a valid instruction at `core_pc` |
| core_daddr | input | 32 | Data access byte address |
| core_dacc_valid | input | 1 | A data access is issued this cycle |
| core_dsize | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| core_dstall | input | 1 | Core stalled on a data access |
| core_bad_instr | input | 1 | Invalid instruction pulse |
| core_bad_fetch | input | 1 | Invalid instruction fetch pulse |
| core_bad_daccess | input | 1 | Invalid data access pulse |
| core_halt_instr | input | 1 | Halt-type instruction executed pulse |
| trap_reg | input | 1 | Register address trap pulse |
| trap_mem | input | 1 | Memory address trap pulse |
| core_halt | output | 1 | Halt request to the core |
| core_pc_load | output | 1 | Load `core_pc_value` into the PC |
| core_pc_value | output | 32 | PC value to load |
| core_dec_flush | output | 1 | Invalidate the decode stage |

## Verification
Read data, the live PC, state bits 10 and 14 follow their inputs in the same cycle. A cause flag or a register write shows up one edge after the stimulus, and so does `core_halt`. The PC load and the flush pulse come one edge after an accepted write and last one cycle. The bench changes inputs on the falling edge and checks combinational results 1 ns later. It checks registered results at the next falling edge, after exactly one rising edge. Its reference model advances once per rising edge, and the halt value that gates the breakpoint is taken from the cycle before that edge.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned OW = 8;
  localparam int unsigned NUM_EV = 10;

  localparam logic [OW-1:0] OFF_MODE  = 8'h00;
  localparam logic [OW-1:0] OFF_STATE = 8'h04;
  localparam logic [OW-1:0] OFF_PC    = 8'h1C;
  localparam logic [OW-1:0] OFF_BP    = 8'h34;

  // state bit positions
  localparam int unsigned B_BP     = 0;
  localparam int unsigned B_HLTI   = 1;
  localparam int unsigned B_BADI   = 2;
  localparam int unsigned B_P0D    = 3;
  localparam int unsigned B_P0I    = 4;
  localparam int unsigned B_BADD   = 5;
  localparam int unsigned B_BADF   = 6;
  localparam int unsigned B_ALIGN  = 7;
  localparam int unsigned B_TMEM   = 8;
  localparam int unsigned B_TREG   = 9;
  localparam int unsigned B_HALTED = 10;
  localparam int unsigned B_STALL  = 14;

  // mode bit positions
  localparam int unsigned M_P0I_EN = 2;
  localparam int unsigned M_P0D_EN = 3;
  localparam int unsigned M_HALT   = 10;

  localparam logic [NUM_EV-1:0] HALT_CAUSES =
    NUM_EV'((1 << B_BP) | (1 << B_HLTI) | (1 << B_BADI) | (1 << B_BADF));

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} dsize_e;

  function automatic logic misaligned(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      SZ_HALF: misaligned = lo[0];
      SZ_WORD: misaligned = |lo;
      default: misaligned = 1'b0;
    endcase
  endfunction

  function automatic logic below_limit(input logic [DW-1:0] addr, input int unsigned limit);
    below_limit = (addr < DW'(limit));
  endfunction
endpackage

// File: rtl/dbg_event_detect.sv
module dbg_event_detect
  import dbg_pkg::*;
#(
  parameter int unsigned PAGE0_BYTES = 256
) (
  input  logic [DW-1:0]     pc,
  input  logic              dec_valid,
  input  logic [DW-1:0]     daddr,
  input  logic              dacc_valid,
  input  logic [1:0]        dsize,
  input  logic              halted,
  input  logic [DW-1:3]     unused_pad,
  input  logic [DW-1:2]     bp_addr,
  input  logic              bp_dis,
  input  logic              p0i_en,
  input  logic              p0d_en,
  input  logic              bad_instr,
  input  logic              bad_fetch,
  input  logic              bad_daccess,
  input  logic              halt_instr,
  input  logic              trap_reg,
  input  logic              trap_mem,
  output logic              bp_hit,
  output logic [NUM_EV-1:0] ev
);
  logic unused_ok;
  assign unused_ok = &unused_pad;

  assign bp_hit = !bp_dis && !halted && dec_valid && (pc == {bp_addr, 2'b00});

  always_comb begin
    ev          = '0;
    ev[B_BP]    = bp_hit;
    ev[B_HLTI]  = halt_instr;
    ev[B_BADI]  = bad_instr;
    ev[B_P0D]   = p0d_en && dacc_valid && below_limit(daddr, PAGE0_BYTES);
    ev[B_P0I]   = p0i_en && dec_valid && below_limit(pc, PAGE0_BYTES);
    ev[B_BADD]  = bad_daccess;
    ev[B_BADF]  = bad_fetch;
    ev[B_ALIGN] = dacc_valid && misaligned(dsize, daddr[1:0]);
    ev[B_TMEM]  = trap_mem;
    ev[B_TREG]  = trap_reg;
  end
endmodule

// File: rtl/dbg_sticky_state.sv
module dbg_sticky_state
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] clr,
  output logic [NUM_EV-1:0] st
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      st[i] <= 1'b0;
      else if (ev[i])  st[i] <= 1'b1;
      else if (clr[i]) st[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_pc_ovr.sv
module dbg_pc_ovr
  import dbg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic [DW-1:0] wdata,
  output logic          pc_load,
  output logic          dec_flush,
  output logic [DW-1:0] pc_value
);
  logic [DW-1:2] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= '0;
      pc_load   <= 1'b0;
      dec_flush <= 1'b0;
    end else begin
      pc_load   <= wr_acc;
      dec_flush <= wr_acc;
      if (wr_acc) pc_q <= wdata[DW-1:2];
    end
  end

  assign pc_value = {pc_q, 2'b00};
endmodule

// File: rtl/cpu_dbg_ctrl.sv
module cpu_dbg_ctrl
  import dbg_pkg::*;
#(
  parameter int unsigned PAGE0_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] core_pc,
  input  logic          core_dec_valid,
  input  logic [DW-1:0] core_daddr,
  input  logic          core_dacc_valid,
  input  logic [1:0]    core_dsize,
  input  logic          core_dstall,
  input  logic          core_bad_instr,
  input  logic          core_bad_fetch,
  input  logic          core_bad_daccess,
  input  logic          core_halt_instr,
  input  logic          trap_reg,
  input  logic          trap_mem,
  output logic          core_halt,
  output logic          core_pc_load,
  output logic [DW-1:0] core_pc_value,
  output logic          core_dec_flush
);
  localparam logic [DW-1:0] MODE_MASK =
    DW'((1 << M_P0I_EN) | (1 << M_P0D_EN) | (1 << M_HALT));

  logic [DW-1:0]     mode_q;
  logic [DW-1:2]     bp_addr_q;
  logic              bp_bit1_q;
  logic              bp_dis_q;
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV-1:0] st;
  logic [NUM_EV-1:0] clr;
  logic              bp_hit;
  logic              mode_halt;
  logic              pc_wr_acc;
  logic              wr_mode, wr_state, wr_bp, wr_pc;

  assign wr_mode   = host_wr && (host_addr == OFF_MODE);
  assign wr_state  = host_wr && (host_addr == OFF_STATE);
  assign wr_bp     = host_wr && (host_addr == OFF_BP);
  assign wr_pc     = host_wr && (host_addr == OFF_PC);
  assign pc_wr_acc = wr_pc && core_halt;
  assign clr       = wr_state ? host_wdata[NUM_EV-1:0] : '0;
  assign mode_halt = mode_q[M_HALT];
  assign core_halt = mode_halt || |(st & HALT_CAUSES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      bp_addr_q <= '0;
      bp_bit1_q <= 1'b0;
      bp_dis_q  <= 1'b1;
    end else begin
      if (wr_mode) mode_q <= host_wdata & MODE_MASK;
      if (wr_bp) begin
        bp_addr_q <= host_wdata[DW-1:2];
        bp_bit1_q <= host_wdata[1];
        bp_dis_q  <= host_wdata[0];
      end
    end
  end

  dbg_event_detect #(.PAGE0_BYTES(PAGE0_BYTES)) u_evt (
    .pc          (core_pc),
    .dec_valid   (core_dec_valid),
    .daddr       (core_daddr),
    .dacc_valid  (core_dacc_valid),
    .dsize       (core_dsize),
    .halted      (core_halt),
    .unused_pad  ({(DW-3){1'b1}}),
    .bp_addr     (bp_addr_q),
    .bp_dis      (bp_dis_q),
    .p0i_en      (mode_q[M_P0I_EN]),
    .p0d_en      (mode_q[M_P0D_EN]),
    .bad_instr   (core_bad_instr),
    .bad_fetch   (core_bad_fetch),
    .bad_daccess (core_bad_daccess),
    .halt_instr  (core_halt_instr),
    .trap_reg    (trap_reg),
    .trap_mem    (trap_mem),
    .bp_hit      (bp_hit),
    .ev          (ev)
  );

  dbg_sticky_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .clr   (clr),
    .st    (st)
  );

  dbg_pc_ovr u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (pc_wr_acc),
    .wdata     (host_wdata),
    .pc_load   (core_pc_load),
    .dec_flush (core_dec_flush),
    .pc_value  (core_pc_value)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFF_MODE:  host_rdata = mode_q;
      OFF_STATE: begin
        host_rdata[NUM_EV-1:0] = st;
        host_rdata[B_HALTED]   = mode_halt;
        host_rdata[B_STALL]    = core_dstall;
      end
      OFF_PC:    host_rdata = {core_pc[DW-1:2], 2'b00};
      OFF_BP:    host_rdata = {bp_addr_q, bp_bit1_q, bp_dis_q};
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cpu_dbg_ctrl_chk.sv
module cpu_dbg_ctrl_chk
  import dbg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OW-1:0]     host_addr,
  input logic              host_wr,
  input logic [DW-1:0]     host_wdata,
  input logic [DW-1:0]     host_rdata,
  input logic [DW-1:0]     core_pc,
  input logic              core_dstall,
  input logic              core_halt,
  input logic              core_pc_load,
  input logic [DW-1:0]     core_pc_value,
  input logic              core_dec_flush,
  input logic              bp_hit,
  input logic              mode_halt,
  input logic [NUM_EV-1:0] ev,
  input logic [NUM_EV-1:0] st
);
  p_pc_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFF_PC && !core_halt) |=> !core_pc_load);

  p_pc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFF_PC && core_halt) |=>
      (core_pc_load && core_dec_flush && core_pc_value == {$past(host_wdata[DW-1:2]), 2'b00}));

  p_pc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFF_PC) |-> (host_rdata == {core_pc[DW-1:2], 2'b00}));

  p_bp_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |=> (st[B_BP] && core_halt));

  p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st & ~$past(st) & ~$past(ev)) == '0));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~st & $past(ev)) == '0));

  p_stall_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFF_STATE) |-> (host_rdata[B_STALL] == core_dstall));

  p_mode_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_halt |-> core_halt);
endmodule

bind cpu_dbg_ctrl cpu_dbg_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_addr      (host_addr),
  .host_wr        (host_wr),
  .host_wdata     (host_wdata),
  .host_rdata     (host_rdata),
  .core_pc        (core_pc),
  .core_dstall    (core_dstall),
  .core_halt      (core_halt),
  .core_pc_load   (core_pc_load),
  .core_pc_value  (core_pc_value),
  .core_dec_flush (core_dec_flush),
  .bp_hit         (bp_hit),
  .mode_halt      (mode_halt),
  .ev             (ev),
  .st             (st)
);

// File: tb/cpu_dbg_ctrl_tb.sv
`timescale 1ns/1ps
module cpu_dbg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [31:0] core_pc = '0;
  logic        core_dec_valid = 1'b0;
  logic [31:0] core_daddr = '0;
  logic        core_dacc_valid = 1'b0;
  logic [1:0]  core_dsize = '0;
  logic        core_dstall = 1'b0;
  logic        core_bad_instr = 1'b0, core_bad_fetch = 1'b0, core_bad_daccess = 1'b0;
  logic        core_halt_instr = 1'b0, trap_reg = 1'b0, trap_mem = 1'b0;
  logic        core_halt, core_pc_load, core_dec_flush;
  logic [31:0] core_pc_value;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_dbg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .core_pc(core_pc),
    .core_dec_valid(core_dec_valid), .core_daddr(core_daddr),
    .core_dacc_valid(core_dacc_valid), .core_dsize(core_dsize),
    .core_dstall(core_dstall), .core_bad_instr(core_bad_instr),
    .core_bad_fetch(core_bad_fetch), .core_bad_daccess(core_bad_daccess),
    .core_halt_instr(core_halt_instr), .trap_reg(trap_reg), .trap_mem(trap_mem),
    .core_halt(core_halt), .core_pc_load(core_pc_load),
    .core_pc_value(core_pc_value), .core_dec_flush(core_dec_flush)
  );

  // reference model
  logic [9:0]  m_st;
  logic [31:0] m_mode;
  logic [31:0] m_bp;

  function automatic logic m_halt_f(input logic [31:0] md, input logic [9:0] s);
    return md[10] | s[0] | s[1] | s[2] | s[6];
  endfunction

  function automatic logic [9:0] m_events(input logic [31:0] md, input logic [31:0] bp,
                                          input logic halted);
    logic [9:0] e = '0;
    logic badal;
    badal = (core_dsize == 2'd2) ? (core_daddr[1:0] != 2'b00) :
            (core_dsize == 2'd1) ? core_daddr[0] : 1'b0;
    e[9] = trap_reg;
    e[8] = trap_mem;
    e[7] = core_dacc_valid & badal;
    e[6] = core_bad_fetch;
    e[5] = core_bad_daccess;
    e[4] = md[2] & core_dec_valid & (core_pc[31:8] == 24'd0);
    e[3] = md[3] & core_dacc_valid & (core_daddr[31:8] == 24'd0);
    e[2] = core_bad_instr;
    e[1] = core_halt_instr;
    e[0] = ~bp[0] & ~halted & core_dec_valid & (core_pc == {bp[31:2], 2'b00});
    return e;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h04: return {17'd0, core_dstall, 3'd0, m_mode[10], m_st};
      8'h1C: return {core_pc[31:2], 2'b00};
      8'h34: return m_bp;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic core_idle();
    core_dec_valid = 0; core_dacc_valid = 0; core_dsize = 0; core_dstall = 0;
    core_bad_instr = 0; core_bad_fetch = 0; core_bad_daccess = 0;
    core_halt_instr = 0; trap_reg = 0; trap_mem = 0;
  endtask

  // write at one edge; returns at the following negedge with strobe off
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(posedge clk); @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    host_addr = a; #1;
    chk(req, host_rdata, exp);
  endtask

  // apply current core inputs across one edge, then idle them
  task automatic tick();
    @(posedge clk); @(negedge clk);
    core_idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int unsigned rnd;
    rnd = $urandom(32'h5eed);
    core_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R12 reset state
    rd_chk("R12 mode reset", 8'h00, 32'h0);
    rd_chk("R12 state reset", 8'h04, 32'h0);
    rd_chk("R12 bp reset", 8'h34, 32'h1);
    rd_chk("R12 unmapped", 8'h08, 32'h0);
    chk("R12 halt reset", {31'd0, core_halt}, 32'd0);
    chk("R12 pc_value reset", core_pc_value, 32'd0);

    // R3 live PC read
    core_pc = 32'h0000_1237;
    rd_chk("R3 pc read running", 8'h1C, 32'h0000_1234);

    // R1 write while running dropped
    wr(8'h1C, 32'h0000_ABCD);
    chk("R1 no load", {31'd0, core_pc_load}, 32'd0);
    chk("R1 value kept", core_pc_value, 32'd0);

    // R12 mode masking, R11 halt, R7 bit10
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R12 mode mask", 8'h00, 32'h0000_040C);
    chk("R11 halt by mode", {31'd0, core_halt}, 32'd1);
    rd_chk("R7 halted mirror", 8'h04, 32'h0000_0400);
    rd_chk("R3 pc read halted", 8'h1C, 32'h0000_1234);

    // R2 accepted write
    wr(8'h1C, 32'h0000_2223);
    chk("R2 load pulse", {30'd0, core_pc_load, core_dec_flush}, 32'd3);
    chk("R2 value", core_pc_value, 32'h0000_2220);
    @(negedge clk);
    chk("R2 single pulse", {30'd0, core_pc_load, core_dec_flush}, 32'd0);

    wr(8'h00, 32'h0);
    chk("R11 resume", {31'd0, core_halt}, 32'd0);

    // R4 breakpoint
    wr(8'h34, 32'h0000_0102);
    rd_chk("R4 bp readback", 8'h34, 32'h0000_0102);
    core_pc = 32'h0000_0100; core_dec_valid = 1; tick();
    rd_chk("R4 bp state", 8'h04, 32'h1);
    chk("R4 bp halts", {31'd0, core_halt}, 32'd1);
    wr(8'h34, 32'h0000_0101);
    wr(8'h04, 32'h0000_0001);
    rd_chk("R5 w1c clears", 8'h04, 32'h0);
    chk("R11 halt released", {31'd0, core_halt}, 32'd0);
    core_pc = 32'h0000_0100; core_dec_valid = 1; tick();
    rd_chk("R4 disabled no hit", 8'h04, 32'h0);

    // R6 event beats clear
    core_bad_daccess = 1; wr(8'h04, 32'h0000_0020); core_idle();
    rd_chk("R6 event wins", 8'h04, 32'h20);
    wr(8'h04, 32'h0000_0000);
    rd_chk("R5 write zero keeps", 8'h04, 32'h20);
    wr(8'h04, 32'h0000_03FF);
    rd_chk("R5 clear all", 8'h04, 32'h0);

    // R8 alignment
    core_dacc_valid = 1; core_dsize = 2; core_daddr = 32'h1002; tick();
    rd_chk("R8 word misaligned", 8'h04, 32'h80);
    wr(8'h04, 32'h80);
    core_dacc_valid = 1; core_dsize = 1; core_daddr = 32'h1003; tick();
    rd_chk("R8 half odd", 8'h04, 32'h80);
    wr(8'h04, 32'h80);
    core_dacc_valid = 1; core_dsize = 1; core_daddr = 32'h1002; tick();
    core_dacc_valid = 1; core_dsize = 0; core_daddr = 32'h1003; tick();
    core_dacc_valid = 1; core_dsize = 3; core_daddr = 32'h1003; tick();
    rd_chk("R8 aligned/byte/rsvd", 8'h04, 32'h0);

    // R9 page zero
    core_pc = 32'h10; core_dec_valid = 1; core_dacc_valid = 1; core_daddr = 32'h80; tick();
    rd_chk("R9 disabled", 8'h04, 32'h0);
    wr(8'h00, 32'h0000_000C);
    core_pc = 32'hFF; core_dec_valid = 1; core_dacc_valid = 1; core_daddr = 32'h80; tick();
    rd_chk("R9 both in page", 8'h04, 32'h18);
    wr(8'h04, 32'h18);
    core_pc = 32'h100; core_dec_valid = 1; core_dacc_valid = 1; core_daddr = 32'h100; tick();
    rd_chk("R9 at 256 none", 8'h04, 32'h0);
    wr(8'h00, 32'h0);

    // R10 pulses, R11 halt causes
    trap_reg = 1; trap_mem = 1; core_bad_fetch = 1; tick();
    rd_chk("R10 traps+fetch", 8'h04, 32'h340);
    chk("R11 fetch halts", {31'd0, core_halt}, 32'd1);
    wr(8'h04, 32'h040);
    chk("R11 traps no halt", {31'd0, core_halt}, 32'd0);
    core_halt_instr = 1; core_bad_instr = 1; tick();
    rd_chk("R10 halt/instr", 8'h04, 32'h306);
    wr(8'h04, 32'h3FF);

    // R7 stall live
    core_dstall = 1;
    rd_chk("R7 stall bit", 8'h04, 32'h4000);
    core_dstall = 0;

    // random phase against the model
    m_st = '0; m_mode = '0; m_bp = 32'h0000_0200;
    wr(8'h34, m_bp);
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] ev;
      logic [31:0] exp_rd;
      int unsigned sel;
      sel = $urandom % 4;
      core_pc = (sel == 0) ? 32'h200 : (sel == 1) ? ($urandom % 512) : $urandom;
      core_dec_valid   = $urandom % 2;
      core_daddr       = ($urandom % 2) ? ($urandom % 512) : $urandom;
      core_dacc_valid  = $urandom % 2;
      core_dsize       = 2'($urandom % 4);
      core_dstall      = $urandom % 2;
      core_bad_instr   = ($urandom % 16) == 0;
      core_bad_fetch   = ($urandom % 16) == 0;
      core_bad_daccess = ($urandom % 16) == 0;
      core_halt_instr  = ($urandom % 16) == 0;
      trap_reg         = ($urandom % 16) == 0;
      trap_mem         = ($urandom % 16) == 0;
      sel = $urandom % 8;
      host_wr    = (sel < 4);
      host_addr  = (sel == 3 || sel == 4) ? 8'h00 : (sel == 5) ? 8'h34 : 8'h04;
      host_wdata = (sel == 3) ? ($urandom & 32'h0000_040C & (($urandom % 3 == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FBFF))
                              : $urandom;
      if (host_addr == 8'h34) host_wr = 0;
      #1;
      exp_rd = m_read(host_addr);
      chk("R5 R7 random read", host_rdata, exp_rd);
      chk("R11 random halt", {31'd0, core_halt}, {31'd0, m_halt_f(m_mode, m_st)});
      ev = m_events(m_mode, m_bp, m_halt_f(m_mode, m_st));
      @(posedge clk);
      if (host_wr && host_addr == 8'h04) m_st = (m_st & ~host_wdata[9:0]) | ev;
      else m_st = m_st | ev;
      if (host_wr && host_addr == 8'h00) m_mode = host_wdata & 32'h0000_040C;
      @(negedge clk);
    end
    host_wr = 0;
    core_idle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule